// File: doc/BRIEF.md
# Video Memory Address and Data Write Port

This block sits between a byte-wide processor register interface and a 16-bit-word video memory. Software loads a 15-bit word address in two byte writes and then sends data one byte at a time. A low-byte data write goes to the low lane of the addressed word. A high-byte data write goes to the high lane. Each data write raises the matching lane strobe toward the memory in the same cycle. The memory address output always shows the block's current address register.

A mode register sets two things. One bit picks which data byte write advances the address. A two-bit field picks the step: 1, 32 or 128 words. This lets software fill memory linearly, or walk down the columns of a 32-word-wide or 128-word-wide map without reloading the address. The address advances at the clock edge that ends the triggering write, so the next data write lands at the new word. The address wraps within the 32K-word space. Other mode bits are accepted but have no effect. The reset input is asynchronous, active-low, and is released through an internal two-stage synchronizer.

Top module: `vram_port`

## Requirements
- R1: In the first cycles after reset release, the address is 0, the step is +1, the low-byte data write advances the address, and `mem_we` is 00.
- R2: A write with `cpu_sel`=0 loads `cpu_wdata` into address bits 7:0 and leaves bits 14:8 unchanged.
- R3: A write with `cpu_sel`=1 loads `cpu_wdata[6:0]` into address bits 14:8. Bit 7 of that byte is discarded, and address bits 7:0 are kept.
- R4: A write with `cpu_sel`=2 (low data) drives `mem_we`=01 in that cycle, with `mem_addr` equal to the current address and the byte on `mem_wdata[7:0]`.
- R5: A write with `cpu_sel`=3 (high data) drives `mem_we`=10 in that cycle, with `mem_addr` equal to the current address and the byte on `mem_wdata[15:8]`.
- R6: A write with `cpu_sel`=4 loads the mode. If mode bit 7 is 0, only low-data writes advance the address. If it is 1, only high-data writes advance it.
- R7: Mode bits 1:0 set the step: 00 gives +1, 01 gives +32, 10 gives +128 and 11 gives +128. The new address is visible on `mem_addr` from the cycle after the triggering write.
- R8: An address advance wraps modulo 32768 words.
- R9: Mode bits 6:2 change neither the address sequence nor the strobes.
- R10: Cycles with `cpu_wr` low, and writes with `cpu_sel` of 5, 6 or 7, leave the address and mode unchanged and keep `mem_we` at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe, one byte per cycle |
| cpu_sel | input | 3 | Register select: 0 addr low, 1 addr high, 2 data low, 3 data high, 4 mode |
| cpu_wdata | input | 8 | Write byte |
| mem_addr | output | 15 | Current word address to memory |
| mem_wdata | output | 16 | Write byte replicated on both lanes |
| mem_we | output | 2 | Lane write enables, bit 0 low lane, bit 1 high lane |

## Verification
A wrong address register shows on `mem_addr` at once. It is also visible with the next lane strobe, in the cycle right after the bad load or advance. A wrong trigger bit or step decode shows up on the first advancing write after a mode load: the next data write lands on the wrong word. Because of the wrap, these errors are easiest to expose near the top of the address space, so the sweeps start there for every step code, trigger side and setting of the unused mode bits.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;
  localparam int ADDR_W = 15;
  localparam int BYTE_W = 8;
  localparam int STEP_MID = 32;
  localparam int STEP_BIG = 128;

  typedef enum logic [2:0] {
    SEL_ADDR_LO = 3'd0,
    SEL_ADDR_HI = 3'd1,
    SEL_DATA_LO = 3'd2,
    SEL_DATA_HI = 3'd3,
    SEL_MODE    = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/vram_rst_sync.sv
module vram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/vram_mode_reg.sv
module vram_mode_reg
  import vram_port_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [7:0]    din,
  output logic          adv_on_hi,
  output logic [1:0]    step_code,
  output logic [AW-1:0] step
);
  logic       hi_q, hi_d;
  logic [1:0] code_q, code_d;

  // next state; bits 6:2 carry no function and are dropped
  always_comb begin
    hi_d   = hi_q;
    code_d = code_q;
    if (load) begin
      hi_d   = din[7];
      code_d = din[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= 1'b0;
      code_q <= 2'b00;
    end else if (load) begin
      hi_q   <= hi_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    unique case (code_q)
      2'b00:   step = AW'(1);
      2'b01:   step = AW'(STEP_MID);
      default: step = AW'(STEP_BIG);
    endcase
  end

  assign adv_on_hi = hi_q;
  assign step_code = code_q;

  // R6: loading the mode captures the trigger bit
  a_r6_trig_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> adv_on_hi == $past(din[7]));
  // R9: mode only changes on a mode write
  a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(step_code) && $stable(adv_on_hi));
endmodule

// File: rtl/vram_addr_reg.sv
module vram_addr_reg
  import vram_port_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          advance,
  input  logic [7:0]    din,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] addr
);
  localparam int HI_W = AW - BYTE_W;

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  assign addr_en = ld_lo | ld_hi | advance;

  always_comb begin
    addr_d = addr_q;
    if (ld_lo)        addr_d = {addr_q[AW-1:BYTE_W], din};
    else if (ld_hi)   addr_d = {din[HI_W-1:0], addr_q[BYTE_W-1:0]};
    else if (advance) addr_d = addr_q + step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

  // R2: low load keeps the upper part
  a_r2_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> addr[BYTE_W-1:0] == $past(din) &&
              addr[AW-1:BYTE_W] == $past(addr[AW-1:BYTE_W]));
  // R3: high load keeps the lower part
  a_r3_hi_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> addr[BYTE_W-1:0] == $past(addr[BYTE_W-1:0]));
endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [2:0]    cpu_sel,
  input  logic [7:0]    cpu_wdata,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  output logic [1:0]    mem_we
);
  logic          rst_i_n;
  logic          wr_alo, wr_ahi, wr_dlo, wr_dhi, wr_mode;
  logic          adv_on_hi, advance;
  logic [1:0]    step_code;
  logic [AW-1:0] step;

  vram_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  assign wr_alo  = cpu_wr && (cpu_sel == SEL_ADDR_LO);
  assign wr_ahi  = cpu_wr && (cpu_sel == SEL_ADDR_HI);
  assign wr_dlo  = cpu_wr && (cpu_sel == SEL_DATA_LO);
  assign wr_dhi  = cpu_wr && (cpu_sel == SEL_DATA_HI);
  assign wr_mode = cpu_wr && (cpu_sel == SEL_MODE);

  vram_mode_reg #(.AW(AW)) u_mode (
    .clk(clk), .rst_n(rst_i_n), .load(wr_mode), .din(cpu_wdata),
    .adv_on_hi(adv_on_hi), .step_code(step_code), .step(step)
  );

  assign advance = adv_on_hi ? wr_dhi : wr_dlo;

  vram_addr_reg #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_i_n), .ld_lo(wr_alo), .ld_hi(wr_ahi),
    .advance(advance), .din(cpu_wdata), .step(step), .addr(mem_addr)
  );

  assign mem_we    = {wr_dhi, wr_dlo};
  assign mem_wdata = {cpu_wdata, cpu_wdata};

  // R4/R5: at most one lane per cycle, only on a bus write
  a_r4_lane_onehot: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(mem_we) && (mem_we == 2'b00 || cpu_wr));
  // R7: advance distance follows the step code, wrapping (R8)
  a_r7_step: assert property (@(posedge clk) disable iff (!rst_i_n)
    advance |=> mem_addr == AW'($past(mem_addr) +
      (($past(step_code) == 2'b00) ? 1 : ($past(step_code) == 2'b01) ? STEP_MID : STEP_BIG)));
  // R10: idle or unmapped writes do not move the address
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!cpu_wr || cpu_sel > 3'd4) |=> $stable(mem_addr));
  // R6: the non-trigger data byte leaves the address alone
  a_r6_no_adv: assert property (@(posedge clk) disable iff (!rst_i_n)
    ((wr_dlo && adv_on_hi) || (wr_dhi && !adv_on_hi)) |=> $stable(mem_addr));
endmodule

// File: tb/vram_port_test.sv
module vram_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [2:0]  cpu_sel = 3'd0;
  logic [7:0]  cpu_wdata = 8'd0;
  logic [14:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [1:0]  mem_we;

  int total = 0;
  int bad = 0;
  logic [14:0] exp_addr;
  logic        exp_hi;
  logic [1:0]  exp_code;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  vram_port uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [14:0] stepv(input logic [1:0] c);
    return (c == 2'b00) ? 15'd1 : (c == 2'b01) ? 15'd32 : 15'd128;
  endfunction

  // drive at negedge, check combinational strobe just after, commit at posedge
  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = s; cpu_wdata = d;
    #2;
    if (s == 3'd2) begin
      chk("R4 we", mem_we, 2'b01);
      chk("R4 addr", mem_addr, exp_addr);
      chk("R4 data", mem_wdata[7:0], d);
    end else if (s == 3'd3) begin
      chk("R5 we", mem_we, 2'b10);
      chk("R5 addr", mem_addr, exp_addr);
      chk("R5 data", mem_wdata[15:8], d);
    end else begin
      chk("R10 we idle", mem_we, 2'b00);
    end
    case (s)
      3'd0: exp_addr[7:0] = d;
      3'd1: exp_addr[14:8] = d[6:0];
      3'd2: if (!exp_hi) exp_addr = exp_addr + stepv(exp_code);
      3'd3: if (exp_hi)  exp_addr = exp_addr + stepv(exp_code);
      3'd4: begin exp_hi = d[7]; exp_code = d[1:0]; end
      default: ;
    endcase
    @(posedge clk);
    #1;
    cpu_wr = 1'b0;
  endtask

  task automatic set_addr(input logic [14:0] a);
    wr(3'd0, a[7:0]);
    wr(3'd1, {1'b1, a[14:8]});  // R3: bit 7 set, must be dropped
    #1;
    chk("R2 R3 load", mem_addr, a);
  endtask

  initial begin
    exp_addr = '0; exp_hi = 1'b0; exp_code = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    chk("R1 addr", mem_addr, 15'd0);
    chk("R1 we", mem_we, 2'b00);
    // R1: default mode advances by 1 on low write
    wr(3'd2, 8'h11);
    #1; chk("R1 default step", mem_addr, 15'd1);
    wr(3'd3, 8'h22);
    #1; chk("R1 high no advance", mem_addr, 15'd1);

    // R2: low load keeps upper bits
    set_addr(15'h1234);
    wr(3'd0, 8'hAB);
    #1; chk("R2 low only", mem_addr, 15'h12AB);

    // sweep: step codes x trigger side x unused mode bits (R6 R7 R8 R9)
    for (int c = 0; c < 4; c++)
      for (int t = 0; t < 2; t++)
        for (int u = 0; u < 4; u++) begin
          wr(3'd4, {t[0], u[1], u[0], u[0], u[1], u[0], c[1:0]});
          set_addr(15'h7FFF - 15'(c * 40));
          for (int k = 0; k < 3; k++) begin
            wr(3'd2, 8'(k + u));
            wr(3'd3, 8'(k + c));
            #1; chk("R7 R8 R9 sequence", mem_addr, exp_addr);
          end
        end

    // R10: unmapped selects and idle cycles
    wr(3'd4, 8'h01);
    set_addr(15'h0400);
    for (int s = 5; s < 8; s++) begin
      wr(3'(s), 8'hFF);
      #1; chk("R10 unmapped", mem_addr, 15'h0400);
    end
    repeat (3) @(negedge clk);
    #2; chk("R10 idle addr", mem_addr, 15'h0400);
    chk("R10 idle we", mem_we, 2'b00);
    wr(3'd2, 8'h5A);
    #1; chk("R10 mode kept R7", mem_addr, 15'h0420);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule